// File: doc/BRIEF.md
# Dual-Enable Static RAM Controller

This block is a byte-wide static memory of 8192 words that is driven through pin-level controls. Two chip enables of opposite polarity qualify every access. The active-high power enable puts the part into a low-power standby that gates off every other input. The active-low select only disables the part and leaves its inputs live. An active-low output enable and an active-low write strobe choose between reading and writing. The data bus is split into a write-data input, a read-data output and an output-drive flag that marks the cycles in which a real part would drive its pins.

All control pins are sampled on the system clock, and the sampled levels are decoded into five modes: standby, disabled, enabled (selected but idle), read and write. While a write is active, the address and data are captured on every cycle. The byte is committed once, on the first cycle in which the write condition ends. The write may end because the strobe rises, because the select rises, or because the power enable falls. The storage is kept as 128 rows of 512 bits. The upper seven address bits pick the row and the lower six pick the byte within it.

Top module: `dual_enable_sram`

## Requirements
- R1: During and right after reset, `driveEn` is 0 and `rdData` is 0.
- R2: When pins are set to read (powerEn=1, selectN=0, writeN=1, outEnN=0) before clock edge k, `driveEn` is 1 and `rdData` holds the stored byte after edge k+1 and not earlier. After the read pins are removed before edge j, `driveEn` stays 1 after edge j and is 0 after edge j+1.
- R3: Whenever `driveEn` is 0, `rdData` is 0. With the part selected and both strobes high (outEnN=1, writeN=1), nothing is driven.
- R4: With selectN=1 (disabled), nothing is driven and a pulse on writeN leaves memory unchanged.
- R5: With powerEn=0 (standby), nothing is driven and writes are ignored, whatever the other pins do.
- R6: With powerEn=1, selectN=0 and writeN=0, a write is in progress whatever outEnN is, and nothing is driven.
- R7: Each write is committed exactly once, when the write condition first ends. The committed byte and address are the ones present on the last sampled cycle in which the write was active. This requirement covers a write ended by writeN rising.
- R8: A write ended by selectN rising while writeN is still low commits the byte.
- R9: A write ended by powerEn falling while writeN is still low commits the byte.
- R10: A read that is sampled in the same cycle as a commit to the same address returns the newly written byte.
- R11: Every one of the 8192 addresses is distinct storage. The row comes from address bits 12..6 and the byte within the row from bits 5..0. Addresses that differ only in row bits, or only in column bits, hold independent data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rstN | input | 1 | Active-low synchronous reset |
| powerEn | input | 1 | Active-high enable; low selects standby and gates the inputs |
| selectN | input | 1 | Active-low select; high disables the part |
| outEnN | input | 1 | Active-low output enable |
| writeN | input | 1 | Active-low write strobe |
| addr | input | 13 | Word address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data; 0 when not driven |
| driveEn | output | 1 | High when the read data would be driven onto the bus |

## Verification
The assertions assume that the pins are held for whole clock cycles and that a write is not restarted in the cycle right after it ends, so each strobe yields one isolated commit. The bench changes every pin on the falling clock edge and always leaves idle cycles between operations. Within those limits it mixes random reads and writes with random end conditions and random output-enable levels during writes. It also runs directed cases for disabled and standby write attempts and for a read that meets a commit in the same cycle.

// File: rtl/desram_pkg.sv
package desram_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_DISABLED,
    MODE_IDLE,
    MODE_READ,
    MODE_WRITE
  } mode_t;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic inGate;   // input buffers open (power enable pin high)
    logic capture;  // write in progress: latch address and data
    logic commit;   // write just ended: store latched byte
    logic readEn;   // sampled read mode
  } strobe_t;

endpackage

// File: rtl/desram_ctrl.sv
module desram_ctrl
  import desram_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    powerEn,
  input  logic    selectN,
  input  logic    outEnN,
  input  logic    writeN,
  output strobe_t strb,
  output logic    driveEn
);

  logic  powerQ;
  logic  selNQ;
  logic  oeNQ;
  logic  wrNQ;
  logic  wasWriting;
  mode_t mode;

  // Control pins are only sampled while the power enable is high.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      powerQ     <= 1'b0;
      selNQ      <= 1'b1;
      oeNQ       <= 1'b1;
      wrNQ       <= 1'b1;
      wasWriting <= 1'b0;
      driveEn    <= 1'b0;
    end else begin
      powerQ <= powerEn;
      if (powerEn) begin
        selNQ <= selectN;
        oeNQ  <= outEnN;
        wrNQ  <= writeN;
      end
      wasWriting <= (mode == MODE_WRITE);
      driveEn    <= (mode == MODE_READ);
    end
  end

  always_comb begin
    if (!powerQ)      mode = MODE_STANDBY;
    else if (selNQ)   mode = MODE_DISABLED;
    else if (!wrNQ)   mode = MODE_WRITE;
    else if (!oeNQ)   mode = MODE_READ;
    else              mode = MODE_IDLE;
  end

  always_comb begin
    strb.inGate  = powerEn;
    strb.capture = (mode == MODE_WRITE);
    strb.commit  = wasWriting && (mode != MODE_WRITE);
    strb.readEn  = (mode == MODE_READ);
  end

endmodule

// File: rtl/desram_datapath.sv
module desram_datapath
  import desram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int ROW_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int COL_W    = ADDR_W - ROW_W;
  localparam int ROWS     = 1 << ROW_W;
  localparam int ROW_BITS = DATA_W << COL_W;
  localparam int LSB_W    = $clog2(ROW_BITS);

  logic [ADDR_W-1:0]   addrQ;
  logic [DATA_W-1:0]   dataQ;
  logic [ADDR_W-1:0]   latchAddr;
  logic [DATA_W-1:0]   latchData;
  logic [ROW_BITS-1:0] rowMem [ROWS];

  logic [ROW_W-1:0]    rdRow;
  logic [ROW_W-1:0]    wrRow;
  logic [LSB_W-1:0]    rdLsb;
  logic [LSB_W-1:0]    wrLsb;
  logic [ROW_BITS-1:0] rdWord;
  logic                forwardHit;

  // Gated input buffers: address and data hold while in standby.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      dataQ     <= '0;
      latchAddr <= '0;
      latchData <= '0;
    end else begin
      if (strb.inGate) begin
        addrQ <= addr;
        dataQ <= wrData;
      end
      if (strb.capture) begin
        latchAddr <= addrQ;
        latchData <= dataQ;
      end
    end
  end

  assign rdRow  = addrQ[ADDR_W-1 -: ROW_W];
  assign wrRow  = latchAddr[ADDR_W-1 -: ROW_W];
  assign rdLsb  = LSB_W'(addrQ[COL_W-1:0]) * LSB_W'(DATA_W);
  assign wrLsb  = LSB_W'(latchAddr[COL_W-1:0]) * LSB_W'(DATA_W);
  assign rdWord = rowMem[rdRow];
  assign forwardHit = strb.commit && (latchAddr == addrQ);

  // Row/column array: one row word, byte lane picked by the column bits.
  always_ff @(posedge clk) begin
    if (strb.commit) begin
      rowMem[wrRow][wrLsb +: DATA_W] <= latchData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (!strb.readEn) begin
      rdData <= '0;
    end else if (forwardHit) begin
      rdData <= latchData;
    end else begin
      rdData <= rdWord[rdLsb +: DATA_W];
    end
  end

endmodule

// File: rtl/dual_enable_sram.sv
module dual_enable_sram
  import desram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int ROW_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerEn,
  input  logic              selectN,
  input  logic              outEnN,
  input  logic              writeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              driveEn
);

  strobe_t strb;

  desram_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .powerEn (powerEn),
    .selectN (selectN),
    .outEnN  (outEnN),
    .writeN  (writeN),
    .strb    (strb),
    .driveEn (driveEn)
  );

  desram_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ROW_W  (ROW_W)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData)
  );

endmodule

// File: rtl/desram_chk.sv
module desram_chk
  import desram_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              powerEn,
  input logic              selectN,
  input logic              outEnN,
  input logic              writeN,
  input logic [DATA_W-1:0] rdData,
  input logic              driveEn,
  input strobe_t           strb
);

  logic readPins;
  logic writePins;
  assign readPins  = powerEn && !selectN && writeN && !outEnN;
  assign writePins = powerEn && !selectN && !writeN;

  AST_DRIVE_FROM_READ: assert property (@(posedge clk) disable iff (!rstN)
    driveEn |-> $past(readPins, 2)); // R2

  AST_READ_GIVES_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN, 2) && $past(rstN, 1) && $past(readPins, 2)) |-> driveEn); // R2

  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !driveEn |-> (rdData == '0)); // R3

  AST_STANDBY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN, 2) && !$past(powerEn, 2)) |-> !driveEn); // R5

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN, 2) && $past(writePins, 2)) |-> !driveEn); // R6

  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !strb.commit); // R7

  AST_COMMIT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> $past(writePins, 2)); // R7

endmodule

bind dual_enable_sram desram_chk #(.DATA_W(DATA_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .powerEn (powerEn),
  .selectN (selectN),
  .outEnN  (outEnN),
  .writeN  (writeN),
  .rdData  (rdData),
  .driveEn (driveEn),
  .strb    (strb)
);

// File: tb/tb_dual_enable_sram.sv
module tb_dual_enable_sram;

  logic        clk = 1'b0;
  logic        rstN;
  logic        powerEn, selectN, outEnN, writeN;
  logic [12:0] addr;
  logic [7:0]  wrData;
  logic [7:0]  rdData;
  logic        driveEn;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [12:0] pool   [16];
  logic [7:0]  refVal [16];

  always #5ns clk = ~clk;

  dual_enable_sram dut (
    .clk(clk), .rstN(rstN), .powerEn(powerEn), .selectN(selectN),
    .outEnN(outEnN), .writeN(writeN), .addr(addr), .wrData(wrData),
    .rdData(rdData), .driveEn(driveEn)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] expDrive(input logic [7:0] d);
    return {1'b1, d};
  endfunction

  task automatic setIdle();
    powerEn = 1'b1; selectN = 1'b1; writeN = 1'b1; outEnN = 1'b1;
  endtask

  task automatic gap();
    @(negedge clk); @(negedge clk);
  endtask

  // kind 0: strobe rises (R7), 1: select rises (R8), 2: power falls (R9)
  task automatic doWrite(input int idx, input logic [7:0] d, input int kind);
    @(negedge clk);
    powerEn = 1'b1; selectN = 1'b0; writeN = 1'b0;
    outEnN = 1'($urandom % 2);
    addr = pool[idx]; wrData = ~d;
    @(negedge clk);
    wrData = d;                          // last active value wins (R7)
    @(negedge clk);
    check("R6 no drive during write", {driveEn, rdData}, 9'h0);
    case (kind)
      0: writeN  = 1'b1;
      1: selectN = 1'b1;
      default: powerEn = 1'b0;
    endcase
    @(negedge clk);
    setIdle();
    gap();
    refVal[idx] = d;
  endtask

  task automatic doRead(input int idx, input string req);
    @(negedge clk);
    powerEn = 1'b1; selectN = 1'b0; writeN = 1'b1; outEnN = 1'b0;
    addr = pool[idx];
    @(negedge clk);
    check({req, " not yet driven"}, {driveEn, rdData}, 9'h0);
    @(negedge clk);
    check({req, " read data"}, {driveEn, rdData}, expDrive(refVal[idx]));
    setIdle();
    @(negedge clk);
    check("R2 drive held one edge", {driveEn, rdData}, expDrive(refVal[idx]));
    @(negedge clk);
    check("R2 drive released", {driveEn, rdData}, 9'h0);
  endtask

  initial begin
    #2ms;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd4242);
    pool[0] = 13'h0000; pool[1] = 13'h0001; pool[2] = 13'h0040;
    pool[3] = 13'h1FFF; pool[4] = 13'h1FBF; pool[5] = 13'h1FFE;
    for (int i = 6; i < 16; i++) pool[i] = 13'($urandom);
    for (int i = 6; i < 16; i++) pool[i] = {pool[i][12:4], 4'(i)};

    rstN = 1'b0; setIdle(); addr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    check("R1 reset state", {driveEn, rdData}, 9'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", {driveEn, rdData}, 9'h0);

    // Fill the pool, distinct bytes on neighbours in row/column (R11)
    for (int i = 0; i < 16; i++) doWrite(i, 8'(8'h11 * i + 8'h3), i % 3);
    for (int i = 0; i < 6; i++) doRead(i, "R11 distinct address");

    // Ending conditions, directed
    doWrite(2, 8'hA5, 0); doRead(2, "R7 strobe-ended write");
    doWrite(3, 8'h5A, 1); doRead(3, "R8 select-ended write");
    doWrite(4, 8'hC3, 2); doRead(4, "R9 power-ended write");
    doRead(0, "R11 col neighbour untouched");

    // Selected but idle
    @(negedge clk);
    powerEn = 1'b1; selectN = 1'b0; writeN = 1'b1; outEnN = 1'b1; addr = pool[1];
    gap();
    check("R3 enabled idle no drive", {driveEn, rdData}, 9'h0);
    setIdle(); gap();

    // Disabled write attempt
    @(negedge clk);
    powerEn = 1'b1; selectN = 1'b1; writeN = 1'b0; outEnN = 1'b0;
    addr = pool[1]; wrData = ~refVal[1];
    gap();
    check("R4 disabled no drive", {driveEn, rdData}, 9'h0);
    writeN = 1'b1; gap(); setIdle(); gap();
    doRead(1, "R4 disabled write ignored");

    // Standby write attempt
    @(negedge clk);
    powerEn = 1'b0; selectN = 1'b0; writeN = 1'b0; outEnN = 1'b0;
    addr = pool[5]; wrData = ~refVal[5];
    gap();
    check("R5 standby no drive", {driveEn, rdData}, 9'h0);
    writeN = 1'b1; gap(); outEnN = 1'b1; selectN = 1'b1; gap();
    setIdle(); gap();
    doRead(5, "R5 standby write ignored");

    // Read meets commit in the same cycle
    @(negedge clk);
    powerEn = 1'b1; selectN = 1'b0; writeN = 1'b0; outEnN = 1'b1;
    addr = pool[7]; wrData = 8'h9C;
    @(negedge clk); @(negedge clk);
    writeN = 1'b1; outEnN = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R10 forwarded byte", {driveEn, rdData}, expDrive(8'h9C));
    refVal[7] = 8'h9C;
    setIdle(); gap(); gap();
    doRead(7, "R10 stored after forward");

    // Random mix
    for (int n = 0; n < 250; n++) begin
      int idx;
      idx = int'($urandom % 16);
      if ($urandom % 2 == 0) doWrite(idx, 8'($urandom), int'($urandom % 3));
      else doRead(idx, "R2 random read");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule